// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Preamble Generation

This block serializes characters onto a single transmit line. Each character goes out as one start bit (low), eight or nine data bits sent least significant bit first, and one stop bit (high). A format input selects the eight- or nine-bit length. When parity is enabled, the most significant data bit position carries an even or odd parity bit instead of data. One character can wait in a holding register while the previous one shifts out, and a buffer-empty flag shows when a new character may be written. Bit timing comes from an external baud tick. Each bit lasts a fixed number of ticks.

Besides data characters, the block produces two special units. A break unit is low for a whole character time and has no start or stop bit. Break units repeat for as long as the break request is held. Once the request drops, the break in progress finishes and exactly one high bit follows it. A preamble unit is high for a whole character time. It is sent whenever the transmit enable rises, ahead of any pending data. This also holds when the enable is dropped and raised again while a character is on the line.

A character time is 10 bit times in eight-bit format and 11 bit times in nine-bit format. Lowering the transmit enable never cuts a character short: the unit in progress always completes.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset, txd is high and buf_empty is high.
- R2: A data character is driven as txd bits in this order: bit 0 is the start bit (0); then 8 data bits (nine_bit=0) or 9 data bits (nine_bit=1), least significant first; then one stop bit (1). Each bit lasts TICKS_PER_BIT baud ticks. A character written while another is shifting starts right after it, so start bits are 10 or 11 bit times apart.
- R3: With par_en=1, the last data bit position (bit 7 for nine_bit=0, bit 8 for nine_bit=1) carries parity instead of data. The parity is computed over the data bits below that position: even parity is their XOR, and odd parity (par_odd=1) is the inverted XOR.
- R4: buf_empty is low in the cycle after a write. It goes high when the held character moves into the shift register.
- R5: While brk_req and tx_en are both high, the transmitter sends break units back to back. A break unit is low for 10 or 11 bit times (following nine_bit) and has no start or stop bit, so the low stretch on txd is a whole number of break units.
- R6: After brk_req falls, the break unit in progress completes. txd is then high for exactly one bit time before the next character starts.
- R7: A rising tx_en causes a preamble (txd high for 10 or 11 bit times) to be sent before the pending character. In the cycle-exact case, the start bit appears 1 + 10·TICKS_PER_BIT cycles after the clock edge that samples the rise (8-bit format, one tick per cycle).
- R8: If tx_en falls while a character is shifting, that character completes correctly. txd then stays high, and a character waiting in the holding register is discarded: buf_empty goes high and nothing is sent. Raising tx_en again with nothing pending sends only a preamble.
- R9: If tx_en is dropped and raised again while a character is shifting, a preamble follows that character and the pending character comes next. Their start bits are then two character times apart.
- R10: While tx_en is low and nothing is in progress, txd stays high even when a character is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| brk_req | input | 1 | Break request, level sensitive |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| baud_tick | input | 1 | Baud tick, one clock wide |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| buf_empty | output | 1 | Holding register is empty |
| txd | output | 1 | Serial output line |

## Verification
The bench builds the block with TICKS_PER_BIT=4. At that setting a long run of three back-to-back break units, the single mark bit after it, and preambles in both the idle and the mid-character case all fit in a few hundred cycles. For those directed cases the baud tick is held at one per cycle, which makes the cycle distances between start bits exact. The random phase then mixes both formats, both parity settings and gaps in the baud tick. In that phase the bench decodes txd by counting baud ticks.

// File: rtl/serial_tx_framer.sv
module serial_tx_framer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       brk_req,
  input  logic       nine_bit,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [8:0] wr_data,
  output logic       buf_empty,
  output logic       txd
);

  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int SW = 11;
  localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_BIT - 1);

  typedef enum logic [2:0] {K_IDLE, K_DATA, K_BRK, K_PRE, K_MARK} kind_t;

  kind_t         kind, nxt;
  logic [SW-1:0] shreg;
  logic [3:0]    bits_left;
  logic [TW-1:0] ticks;
  logic [8:0]    dreg;
  logic          pre_pend, te_q, brk_last;

  logic bit_end, unit_end, free, want_pre, par_bit;
  logic [3:0]    unit_len;
  logic [SW-1:0] frame_vec;

  assign bit_end  = (kind != K_IDLE) && baud_tick && (ticks == LAST_TICK);
  assign unit_end = bit_end && (bits_left == 4'd1);
  assign free     = (kind == K_IDLE) || unit_end;
  assign want_pre = pre_pend || (tx_en && !te_q);
  assign unit_len = nine_bit ? 4'd11 : 4'd10;
  assign par_bit  = (nine_bit ? ^dreg[7:0] : ^dreg[6:0]) ^ par_odd;
  assign frame_vec = nine_bit ? {1'b1, (par_en ? par_bit : dreg[8]), dreg[7:0], 1'b0}
                              : {2'b11, (par_en ? par_bit : dreg[7]), dreg[6:0], 1'b0};
  assign txd = (kind == K_IDLE) ? 1'b1 : shreg[0];

  always_comb begin
    nxt = K_IDLE;
    if (brk_last && !brk_req)  nxt = K_MARK;
    else if (tx_en && brk_req) nxt = K_BRK;
    else if (tx_en && want_pre) nxt = K_PRE;
    else if (tx_en && !buf_empty) nxt = K_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind      <= K_IDLE;
      shreg     <= '1;
      bits_left <= '0;
      ticks     <= '0;
      te_q      <= 1'b0;
      brk_last  <= 1'b0;
    end else begin
      te_q <= tx_en;
      if (free) begin
        kind  <= nxt;
        ticks <= '0;
        case (nxt)
          K_MARK: begin shreg <= '1;        bits_left <= 4'd1;     brk_last <= 1'b0; end
          K_BRK:  begin shreg <= '0;        bits_left <= unit_len; brk_last <= 1'b1; end
          K_PRE:  begin shreg <= '1;        bits_left <= unit_len; end
          K_DATA: begin shreg <= frame_vec; bits_left <= unit_len; end
          default: bits_left <= '0;
        endcase
      end else if (kind != K_IDLE && baud_tick) begin
        if (ticks == LAST_TICK) begin
          ticks     <= '0;
          shreg     <= {1'b1, shreg[SW-1:1]};
          bits_left <= bits_left - 4'd1;
        end else begin
          ticks <= ticks + TW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_pend <= 1'b0;
    end else if (free && nxt == K_PRE) begin
      pre_pend <= 1'b0;
    end else if (tx_en && !te_q) begin
      pre_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg      <= '0;
      buf_empty <= 1'b1;
    end else if (wr_en) begin
      dreg      <= wr_data;
      buf_empty <= 1'b0;
    end else if ((free && nxt == K_DATA) || (unit_end && !tx_en)) begin
      buf_empty <= 1'b1;
    end
  end

  a_r4_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty);
  a_r5_break_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BRK) |-> !txd);
  a_r7_preamble_is_high: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_PRE) |-> txd);
  a_r6_mark_after_break: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BRK && unit_end && !brk_req) |=> (kind == K_MARK));
  a_r10_no_start_while_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_IDLE && !tx_en) |=> (kind == K_IDLE || kind == K_MARK));
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != K_IDLE) |-> (bits_left >= 4'd1 && bits_left <= 4'd11));

endmodule

// File: tb/serial_tx_framer_tb.sv
`timescale 1ns/1ps
module serial_tx_framer_tb_top;
  localparam int T  = 4;
  localparam int NR = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, brk_req = 0, nine_bit = 0, par_en = 0, par_odd = 0;
  logic baud_tick = 1'b1, wr_en = 0;
  logic [8:0] wr_data = '0;
  logic buf_empty, txd;
  logic gap_mode = 1'b0;
  int cyc = 0, checks = 0, fails = 0;

  logic [8:0] rd [NR];
  logic       rm [NR];
  logic       rpe [NR];
  logic       rpo [NR];

  serial_tx_framer #(.TICKS_PER_BIT(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req), .nine_bit(nine_bit),
    .par_en(par_en), .par_odd(par_odd), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .buf_empty(buf_empty), .txd(txd));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) baud_tick <= gap_mode ? ($urandom_range(0, 2) != 0) : 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic m, input logic pe, input logic po,
                                            input logic [8:0] d);
    logic pb;
    if (m) begin
      pb = (^d[7:0]) ^ po;
      return {1'b1, (pe ? pb : d[8]), d[7:0], 1'b0};
    end
    pb = (^d[6:0]) ^ po;
    return {2'b11, (pe ? pb : d[7]), d[6:0], 1'b0};
  endfunction

  function automatic logic [10:0] mask(input logic m, input logic [10:0] v);
    return m ? v : {1'b1, v[9:0]};
  endfunction

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (baud_tick) c++;
    end
  endtask

  task automatic wait_fall(output int fc);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    fc = cyc;
  endtask

  task automatic decode_from_fall(input logic m, output logic [10:0] b);
    int len = m ? 11 : 10;
    b = '1;
    wait_ticks(T / 2);
    @(negedge clk);
    b[0] = txd;
    for (int k = 1; k < len; k++) begin
      wait_ticks(T);
      @(negedge clk);
      b[k] = txd;
    end
  endtask

  task automatic write_char(input logic [8:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_empty();
    @(negedge clk);
    while (!buf_empty) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [10:0] b1, b2;
    int f1, f2, c0, lowc, highc;
    bit seen_low;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd after reset", txd, 1);
    chk("R1 buf_empty after reset", buf_empty, 1);

    // R10: pending data with enable low is not sent
    write_char(9'h0A5);
    chk("R4 empty clears after write", buf_empty, 0);
    seen_low = 0;
    repeat (20) begin @(negedge clk); if (!txd) seen_low = 1; end
    chk("R10 line idle with enable low", seen_low, 0);

    // R7: preamble ahead of pending data
    tx_en = 1'b1;
    c0 = cyc;
    wait_fall(f1);
    chk("R7 preamble delay in cycles", f1 - c0, 1 + 10 * T);
    chk("R4 empty after load", buf_empty, 1);
    decode_from_fall(1'b0, b1);
    chk("R2 frame after preamble", mask(0, b1), mask(0, exp_frame(0, 0, 0, 9'h0A5)));
    repeat (10) @(negedge clk);

    // R2/R3: nine-bit odd parity, back to back
    nine_bit = 1; par_en = 1; par_odd = 1;
    fork
      begin
        write_char(9'h1C3);
        wait_empty();
        write_char(9'h03C);
      end
      begin
        wait_fall(f1); decode_from_fall(1'b1, b1);
        wait_fall(f2); decode_from_fall(1'b1, b2);
      end
    join
    chk("R3 nine-bit odd parity frame A", b1, exp_frame(1, 1, 1, 9'h1C3));
    chk("R3 nine-bit odd parity frame B", b2, exp_frame(1, 1, 1, 9'h03C));
    chk("R2 back to back spacing", f2 - f1, 11 * T);
    repeat (10) @(negedge clk);

    // R5/R6: held break, then a single mark bit
    par_en = 0; par_odd = 0;
    @(negedge clk);
    brk_req = 1'b1;
    @(negedge clk);
    lowc = (txd == 1'b0) ? 1 : 0;
    wr_data = 9'h155; wr_en = 1'b1;
    repeat (2 * 11 * T + 2) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (!txd) lowc++;
    end
    brk_req = 1'b0;
    @(negedge clk);
    while (!txd) begin lowc++; @(negedge clk); end
    chk("R5 break low run is three units", lowc, 3 * 11 * T);
    highc = 0;
    while (txd) begin highc++; @(negedge clk); end
    chk("R6 one mark bit after break", highc, T);
    decode_from_fall(1'b1, b1);
    chk("R6 character after break", b1, exp_frame(1, 0, 0, 9'h155));
    repeat (10) @(negedge clk);

    // R8: enable dropped mid character, pending data discarded
    nine_bit = 0; par_en = 1; par_odd = 0;
    fork
      begin
        write_char(9'h0E7);
        wait_empty();
        write_char(9'h012);
        repeat (6) @(negedge clk);
        tx_en = 1'b0;
      end
      begin
        wait_fall(f1); decode_from_fall(1'b0, b1);
      end
    join
    chk("R8 character in flight completes", mask(0, b1), mask(0, exp_frame(0, 1, 0, 9'h0E7)));
    seen_low = 0;
    repeat (3 * 10 * T) begin @(negedge clk); if (!txd) seen_low = 1; end
    chk("R8 line stays high after disable", seen_low, 0);
    chk("R8 pending data discarded", buf_empty, 1);
    tx_en = 1'b1;
    seen_low = 0;
    repeat (10 * T + 8) begin @(negedge clk); if (!txd) seen_low = 1; end
    chk("R8 re-enable sends preamble only", seen_low, 0);
    chk("R8 nothing left pending", buf_empty, 1);
    repeat (10) @(negedge clk);

    // R9: enable toggled mid character queues a preamble
    par_en = 0;
    fork
      begin
        write_char(9'h0B1);
        wait_empty();
        write_char(9'h04E);
        repeat (5) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
      end
      begin
        wait_fall(f1); decode_from_fall(1'b0, b1);
        wait_fall(f2); decode_from_fall(1'b0, b2);
      end
    join
    chk("R9 first character", mask(0, b1), mask(0, exp_frame(0, 0, 0, 9'h0B1)));
    chk("R9 character after queued preamble", mask(0, b2), mask(0, exp_frame(0, 0, 0, 9'h04E)));
    chk("R9 start spacing includes preamble", f2 - f1, 2 * 10 * T);
    repeat (10) @(negedge clk);

    // random phase: R2, R3, R4 with baud tick gaps
    gap_mode = 1'b1;
    fork
      begin
        for (int i = 0; i < NR; i++) begin
          wait_empty();
          if ($urandom_range(0, 3) == 0) repeat (30) @(negedge clk);
          rm[i]  = 1'($urandom_range(0, 1));
          rpe[i] = 1'($urandom_range(0, 1));
          rpo[i] = 1'($urandom_range(0, 1));
          rd[i]  = 9'($urandom);
          nine_bit = rm[i]; par_en = rpe[i]; par_odd = rpo[i];
          write_char(rd[i]);
          chk("R4 empty low after random write", buf_empty, 0);
        end
      end
      begin
        for (int i = 0; i < NR; i++) begin
          logic [10:0] rb;
          int fr;
          wait_fall(fr);
          decode_from_fall(rm[i], rb);
          chk("R2 R3 random frame", mask(rm[i], rb),
              mask(rm[i], exp_frame(rm[i], rpe[i], rpo[i], rd[i])));
        end
      end
    join

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule